// File: doc/BRIEF.md
# Transmit Gate and Modulation Pin Conditioner

This block sits between the external control pins of a radio transceiver and its transmit path. It brings the gate, modulation and slice-hold pins into the timing-clock domain, applies a configurable polarity to each pin, and produces three qualified control levels. The first is an internal transmit gate enable that starts the output power ramp. The second is an effective modulation enable, which opens the synthesiser loop. The third is an effective slice-hold enable for the receive data slicer. A configuration flag can move the modulation request from its own pin onto the slice-hold pin.

The block also drives an active-low enable for an external power amplifier. This enable follows the qualified gate after a short, programmable assert delay. When the gate goes inactive, it is held for a longer, programmable release delay, so that the amplifier stays on until the internal power ramp has reached its leakage level. Both delays are counted in timing-clock cycles. While transmit power is disabled, the amplifier enable is kept inactive.

Top module: `tx_pin_ctrl`

## Requirements
- R1: During reset, and until the synchroniser has been filled after reset, every pin reads as inactive whatever its level and polarity. tx_gate_en reads 0 and pa_gate_n reads 1. mod_en_eff and slice_hold_eff equal their force flags.
- R2: tx_gate_en is 1 exactly when the synchronised gate pin equals gate_active_high (1 means the pin is active high, 0 means active low).
- R3: The modulation request pin is mod_pin when mod_on_hold_pin = 0 and hold_pin when mod_on_hold_pin = 1. It is active when its synchronised level equals mod_active_high.
- R4: mod_en_eff = mod_force OR (modulation request pin active).
- R5: slice_hold_eff = hold_force OR (synchronised hold_pin equals hold_active_high). This holds regardless of mod_on_hold_pin.
- R6: A pin change reaches tx_gate_en, mod_en_eff and slice_hold_eff after SYNC_STAGES rising clock edges (2 by default).
- R7: While tx_power_en = 1, pa_gate_n goes low ASSERT_DLY+1 cycles after tx_gate_en rises. A gate activation that ends earlier leaves pa_gate_n high.
- R8: pa_gate_n returns high RELEASE_DLY+1 cycles after tx_gate_en falls, provided the gate stays inactive for that whole time.
- R9: If the gate becomes active again during the release delay, the release is cancelled and pa_gate_n stays low without a glitch.
- R10: When tx_power_en = 0, pa_gate_n is high from the next clock edge on, and gate activity has no effect on it. When power returns with the gate already active, the assert delay starts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_pin | input | 1 | Raw transmit gate pin |
| mod_pin | input | 1 | Raw modulation pin |
| hold_pin | input | 1 | Raw slice-hold pin |
| gate_active_high | input | 1 | Gate pin polarity: 1 = active high |
| mod_active_high | input | 1 | Modulation request polarity: 1 = active high |
| mod_force | input | 1 | Modulation enable flag |
| mod_on_hold_pin | input | 1 | 1 = modulation request taken from hold_pin |
| hold_active_high | input | 1 | Hold pin polarity: 1 = active high |
| hold_force | input | 1 | Slice-hold enable flag |
| tx_power_en | input | 1 | Transmit power enabled |
| tx_gate_en | output | 1 | Qualified internal gate enable |
| mod_en_eff | output | 1 | Effective modulation enable |
| slice_hold_eff | output | 1 | Effective slice hold |
| pa_gate_n | output | 1 | Active-low external amplifier enable |

## Verification
A polarity or select fault in the qualifier shows on the three level outputs exactly SYNC_STAGES edges after the pins settle. Each vector therefore exposes it with no further stimulus. A fault in the amplifier sequencer's state or counter moves the falling or rising edge of pa_gate_n away from its expected edge by at least one cycle. It can also produce a spurious pulse during a short gate, a cancelled release or a power-off period. To catch these, the bench samples pa_gate_n on the cycle just before and just after each expected transition, and on every cycle of the windows where the level must not change.

// File: rtl/tx_pin_pkg.sv
package tx_pin_pkg;
  typedef enum logic [1:0] {
    PA_IDLE = 2'd0,
    PA_ARM  = 2'd1,
    PA_ON   = 2'd2,
    PA_REL  = 2'd3
  } pa_state_e;

  localparam int PIN_GATE = 0;
  localparam int PIN_MOD  = 1;
  localparam int PIN_HOLD = 2;
  localparam int PIN_NUM  = 3;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             valid
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];
  logic [STAGES-1:0] fill_q, fill_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    fill_d = {fill_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      fill_q <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
      fill_q <= fill_d;
    end
  end

  assign dout  = stg_q[STAGES-1];
  assign valid = fill_q[STAGES-1];
endmodule

// File: rtl/pin_qualify.sv
module pin_qualify
  import tx_pin_pkg::*;
(
  input  logic [PIN_NUM-1:0] pins_s,
  input  logic               pins_valid,
  input  logic               gate_active_high,
  input  logic               mod_active_high,
  input  logic               mod_force,
  input  logic               mod_on_hold_pin,
  input  logic               hold_active_high,
  input  logic               hold_force,
  output logic               gate_act,
  output logic               mod_eff,
  output logic               hold_eff
);
  logic mod_src;
  logic mod_pin_act;
  logic hold_pin_act;

  always_comb begin
    mod_src      = mod_on_hold_pin ? pins_s[PIN_HOLD] : pins_s[PIN_MOD];
    gate_act     = pins_valid & (pins_s[PIN_GATE] == gate_active_high);
    mod_pin_act  = pins_valid & (mod_src == mod_active_high);
    hold_pin_act = pins_valid & (pins_s[PIN_HOLD] == hold_active_high);
    mod_eff      = mod_force | mod_pin_act;
    hold_eff     = hold_force | hold_pin_act;
  end
endmodule

// File: rtl/pa_gate_seq.sv
module pa_gate_seq
  import tx_pin_pkg::*;
#(
  parameter int ASSERT_DLY  = 4,
  parameter int RELEASE_DLY = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_act,
  input  logic power_en,
  output logic pa_gate_n
);
  localparam int CNT_MAX = (ASSERT_DLY > RELEASE_DLY) ? ASSERT_DLY : RELEASE_DLY;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] ASSERT_LAST  = CW'(ASSERT_DLY - 1);
  localparam logic [CW-1:0] RELEASE_LAST = CW'(RELEASE_DLY - 1);

  pa_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (!power_en) begin
      state_d = PA_IDLE;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      unique case (state_q)
        PA_IDLE: if (gate_act) begin
          state_d = PA_ARM;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
        PA_ARM: begin
          if (!gate_act) state_d = PA_IDLE;
          else if (cnt_q == ASSERT_LAST) state_d = PA_ON;
          else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
        PA_ON: if (!gate_act) begin
          state_d = PA_REL;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
        PA_REL: begin
          if (gate_act) state_d = PA_ON;
          else if (cnt_q == RELEASE_LAST) state_d = PA_IDLE;
          else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: state_d = PA_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PA_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pa_gate_n = !((state_q == PA_ON) || (state_q == PA_REL));

  assert_pa_off_unpowered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !power_en |=> pa_gate_n);
  assert_pa_on_needs_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pa_gate_n) |-> $past(gate_act));
  assert_pa_off_needs_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_gate_n) |-> (!$past(gate_act) || !$past(power_en)));
  assert_pa_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pa_gate_n && gate_act && power_en) |=> !pa_gate_n);
  assert_arm_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PA_ARM) |-> (cnt_q <= ASSERT_LAST));
endmodule

// File: rtl/tx_pin_ctrl.sv
module tx_pin_ctrl
  import tx_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ASSERT_DLY  = 4,
  parameter int RELEASE_DLY = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_pin,
  input  logic mod_pin,
  input  logic hold_pin,
  input  logic gate_active_high,
  input  logic mod_active_high,
  input  logic mod_force,
  input  logic mod_on_hold_pin,
  input  logic hold_active_high,
  input  logic hold_force,
  input  logic tx_power_en,
  output logic tx_gate_en,
  output logic mod_en_eff,
  output logic slice_hold_eff,
  output logic pa_gate_n
);
  logic [PIN_NUM-1:0] pins_raw;
  logic [PIN_NUM-1:0] pins_s;
  logic               pins_valid;
  logic               gate_act;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_GATE] = gate_pin;
    pins_raw[PIN_MOD]  = mod_pin;
    pins_raw[PIN_HOLD] = hold_pin;
  end

  pin_sync #(.WIDTH(PIN_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pins_raw),
    .dout  (pins_s),
    .valid (pins_valid)
  );

  pin_qualify u_qual (
    .pins_s           (pins_s),
    .pins_valid       (pins_valid),
    .gate_active_high (gate_active_high),
    .mod_active_high  (mod_active_high),
    .mod_force        (mod_force),
    .mod_on_hold_pin  (mod_on_hold_pin),
    .hold_active_high (hold_active_high),
    .hold_force       (hold_force),
    .gate_act         (gate_act),
    .mod_eff          (mod_en_eff),
    .hold_eff         (slice_hold_eff)
  );

  pa_gate_seq #(.ASSERT_DLY(ASSERT_DLY), .RELEASE_DLY(RELEASE_DLY)) u_pa (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_act  (gate_act),
    .power_en  (tx_power_en),
    .pa_gate_n (pa_gate_n)
  );

  assign tx_gate_en = gate_act;

  assert_force_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mod_force) && mod_force |-> mod_en_eff);
  assert_pa_implies_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pa_gate_n) |-> tx_power_en);
endmodule

// File: tb/tx_pin_ctrl_test.sv
module tx_pin_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADLY = 3;
  localparam int RDLY = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic gate_pin, mod_pin, hold_pin;
  logic gate_active_high, mod_active_high, mod_force, mod_on_hold_pin;
  logic hold_active_high, hold_force, tx_power_en;
  logic tx_gate_en, mod_en_eff, slice_hold_eff, pa_gate_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_pin_ctrl #(.SYNC_STAGES(2), .ASSERT_DLY(ADLY), .RELEASE_DLY(RDLY)) uut (
    .clk(clk), .rst_n(rst_n), .gate_pin(gate_pin), .mod_pin(mod_pin), .hold_pin(hold_pin),
    .gate_active_high(gate_active_high), .mod_active_high(mod_active_high),
    .mod_force(mod_force), .mod_on_hold_pin(mod_on_hold_pin),
    .hold_active_high(hold_active_high), .hold_force(hold_force),
    .tx_power_en(tx_power_en), .tx_gate_en(tx_gate_en), .mod_en_eff(mod_en_eff),
    .slice_hold_eff(slice_hold_eff), .pa_gate_n(pa_gate_n)
  );

  // {gate_pol, gate, mod_pol, mod_force, mod_sel, mod, hold, hold_pol, hold_force, exp_gate, exp_mod, exp_hold}
  localparam logic [11:0] VEC [8] = '{
    12'b111001010_110,
    12'b010000100_010,
    12'b001000000_101,
    12'b101100011_011,
    12'b111010110_111,
    12'b001011000_101,
    12'b010010010_010,
    12'b110001110_101
  };

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit seen_low;
    rst_n = 1'b0;
    gate_pin = 1'b0; mod_pin = 1'b0; hold_pin = 1'b0;
    gate_active_high = 1'b0; mod_active_high = 1'b0; mod_force = 1'b0;
    mod_on_hold_pin = 1'b0; hold_active_high = 1'b0; hold_force = 1'b0;
    tx_power_en = 1'b1;
    tick(3);
    // R1: active-low pins at 0 still read inactive in reset
    check("R1 gate in reset", tx_gate_en, 1'b0);
    check("R1 mod in reset", mod_en_eff, 1'b0);
    check("R1 hold in reset", slice_hold_eff, 1'b0);
    check("R1 pa in reset", pa_gate_n, 1'b1);
    rst_n = 1'b1;
    tick(1);
    check("R1 gate before fill", tx_gate_en, 1'b0);
    tick(1);
    check("R6 gate after fill", tx_gate_en, 1'b1);
    check("R6 mod after fill", mod_en_eff, 1'b1);

    // vector walk, power off so PA stays quiet
    tx_power_en = 1'b0;
    for (int v = 0; v < 8; v++) begin
      {gate_active_high, gate_pin, mod_active_high, mod_force, mod_on_hold_pin,
       mod_pin, hold_pin, hold_active_high, hold_force} = VEC[v][11:3];
      tick(2);
      check("R2 gate polarity", tx_gate_en, VEC[v][2]);
      check("R3 R4 mod select/force", mod_en_eff, VEC[v][1]);
      check("R5 hold polarity/force", slice_hold_eff, VEC[v][0]);
      check("R10 pa off unpowered", pa_gate_n, 1'b1);
    end

    // R6 latency: one edge is not enough
    gate_active_high = 1'b1; gate_pin = 1'b0; mod_force = 1'b0; hold_force = 1'b0;
    tick(3);
    gate_pin = 1'b1;
    tick(1);
    check("R6 not yet", tx_gate_en, 1'b0);
    tick(1);
    check("R6 after two edges", tx_gate_en, 1'b1);
    gate_pin = 1'b0;
    tick(4);

    // R7 assert timing
    tx_power_en = 1'b1;
    tick(2);
    gate_pin = 1'b1;
    tick(ADLY + 2);
    check("R7 pa before delay", pa_gate_n, 1'b1);
    tick(1);
    check("R7 pa asserted", pa_gate_n, 1'b0);

    // R8 release timing
    gate_pin = 1'b0;
    tick(RDLY + 2);
    check("R8 pa held in release", pa_gate_n, 1'b0);
    tick(1);
    check("R8 pa released", pa_gate_n, 1'b1);
    tick(4);

    // R7 short pulse never asserts
    gate_pin = 1'b1;
    tick(2);
    gate_pin = 1'b0;
    seen_low = 1'b0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (pa_gate_n == 1'b0) seen_low = 1'b1;
    end
    check("R7 short pulse ignored", seen_low, 1'b0);

    // R9 re-activation cancels release
    gate_pin = 1'b1;
    tick(ADLY + 3);
    check("R9 pa on before gap", pa_gate_n, 1'b0);
    gate_pin = 1'b0;
    tick(4);
    gate_pin = 1'b1;
    seen_low = 1'b1;
    for (int i = 0; i < RDLY + 8; i++) begin
      tick(1);
      if (pa_gate_n == 1'b1) seen_low = 1'b0;
    end
    check("R9 release cancelled", seen_low, 1'b1);

    // R10 power drop forces pa off next edge
    tx_power_en = 1'b0;
    tick(1);
    check("R10 pa off after power drop", pa_gate_n, 1'b1);
    seen_low = 1'b0;
    for (int i = 0; i < 16; i++) begin
      gate_pin = ~gate_pin;
      tick(1);
      if (pa_gate_n == 1'b0) seen_low = 1'b1;
    end
    check("R10 gate ignored unpowered", seen_low, 1'b0);
    gate_pin = 1'b1;
    tick(3);
    tx_power_en = 1'b1;
    tick(ADLY);
    check("R10 restart delay not done", pa_gate_n, 1'b1);
    tick(1);
    check("R10 restart asserted", pa_gate_n, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule